// File: doc/BRIEF.md
# Watchdog Key-Sequence Reset Controller

This block is the watchdog side of a 64-bit timer. Software arms it by writing two different 16-bit keys into the control register, one after the other. Once armed, a 64-bit counter runs. Software must keep servicing the watchdog with the same two keys, in the same order, before the counter catches up with a 64-bit period. A late service, or any unexpected key while armed, raises a one-cycle system reset request. A sticky flag records that such a request happened.

The counter and period are loaded through the same write port while the unit is still disarmed. Once arming begins, they are locked. The watchdog only reacts when the global timer mode selects watchdog operation and both timer halves are out of reset. At any other time it holds its state and its count.

Top module: `wdog_keyguard`

## Requirements
- R1: After reset, `wdt_state` is 0 (disarmed), `wdt_rst_pulse` is 0 and `wdt_fired` is 0.
- R2: While disarmed, a write to offset 0x28 with key bits [31:16] = 0xA5C6 and enable bit 14 set moves `wdt_state` to 1 (pre-armed). Any other control write, including 0xA5C6 with bit 14 clear, leaves the unit disarmed.
- R3: While pre-armed, a control write with key 0xDA7E moves `wdt_state` to 2 (armed). Other keys leave it pre-armed, and software has no way back to disarmed.
- R4: Key writes and counting take effect only while `glb_mode` = 2'b10 and `half_run` = 2'b11. At other times, state and count hold and no reset is requested.
- R5: While armed, the 64-bit counter advances once per cycle, with carry across bit 31. A reset is requested when it equals the period. With count C and period P at arming, the pulse appears P−C+1 cycles after the arming write.
- R6: A zero period with a zero count requests reset in the first cycle after arming.
- R7: While armed, key 0xA5C6 moves `wdt_state` to 3 (service half done). A following 0xDA7E returns it to 2 and clears the counter to zero.
- R8: While armed, any key other than the one expected next requests reset. This covers 0xDA7E in state 2, 0xA5C6 in state 3, and key 0.
- R9: The reset request lasts exactly one cycle. It returns `wdt_state` to 0 and sets `wdt_fired`, which stays set until `rst_n`.
- R10: Writes to counter low/high (0x10/0x14) and period low/high (0x18/0x1C) are accepted only while disarmed.
- R11: When expiry coincides with a bad key or with a service completion, exactly one single-cycle request is issued, and expiry is not cancelled by the service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| glb_mode | input | 2 | Timer mode from global control; 2'b10 selects watchdog |
| half_run | input | 2 | Per-half reset release, both set to run |
| wdt_rst_pulse | output | 1 | One-cycle system reset request |
| wdt_fired | output | 1 | Sticky: a watchdog reset was requested |
| wdt_state | output | 2 | 0 disarmed, 1 pre-armed, 2 armed, 3 service half done |

## Verification
Counter expiry can coincide with a key write in the same clock edge. The bench steers this by counting cycles from the arming write. It then places either a bad key or the closing 0xDA7E of a service exactly on the edge where the count equals the period. Both cases pass only if a single one-cycle pulse appears on that edge, the unit returns to disarmed, and no second pulse follows.

// File: rtl/wdog_keyguard.sv
module wdog_keyguard #(
  parameter int          AW       = 8,
  parameter logic [15:0] KEY_ONE  = 16'hA5C6,
  parameter logic [15:0] KEY_TWO  = 16'hDA7E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [1:0]    glb_mode,
  input  logic [1:0]    half_run,
  output logic          wdt_rst_pulse,
  output logic          wdt_fired,
  output logic [1:0]    wdt_state
);
  localparam logic [AW-1:0] A_CNT_LO = AW'(8'h10);
  localparam logic [AW-1:0] A_CNT_HI = AW'(8'h14);
  localparam logic [AW-1:0] A_PRD_LO = AW'(8'h18);
  localparam logic [AW-1:0] A_PRD_HI = AW'(8'h1C);
  localparam logic [AW-1:0] A_CTL    = AW'(8'h28);
  localparam int            EN_BIT   = 14;

  typedef enum logic [1:0] {S_OFF = 2'd0, S_PRE = 2'd1, S_ARM = 2'd2, S_HALF = 2'd3} st_t;

  st_t         st;
  logic [63:0] cnt, prd;

  wire  [15:0] key     = wr_data[31:16];
  wire         run_ok  = (glb_mode == 2'b10) && (half_run == 2'b11);
  wire         key_wr  = wr_en && (wr_addr == A_CTL) && run_ok;
  wire         armed   = (st == S_ARM) || (st == S_HALF);
  wire         expire  = armed && run_ok && (cnt == prd);
  wire         bad_key = key_wr && (((st == S_ARM) && (key != KEY_ONE)) ||
                                    ((st == S_HALF) && (key != KEY_TWO)));
  wire         fire    = expire || bad_key;
  wire         svc_end = key_wr && (st == S_HALF) && (key == KEY_TWO);
  wire         load_ok = wr_en && (st == S_OFF);

  assign wdt_state = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_OFF;
      cnt           <= '0;
      prd           <= '0;
      wdt_rst_pulse <= 1'b0;
      wdt_fired     <= 1'b0;
    end else begin
      wdt_rst_pulse <= fire;
      if (fire) wdt_fired <= 1'b1;

      if (fire) st <= S_OFF;
      else if (key_wr) begin
        case (st)
          S_OFF:   if (key == KEY_ONE && wr_data[EN_BIT]) st <= S_PRE;
          S_PRE:   if (key == KEY_TWO) st <= S_ARM;
          S_ARM:   st <= S_HALF;
          default: st <= S_ARM;
        endcase
      end

      if (fire || svc_end) cnt <= '0;
      else if (armed && run_ok) cnt <= cnt + 64'd1;
      else if (load_ok && wr_addr == A_CNT_LO) cnt[31:0]  <= wr_data;
      else if (load_ok && wr_addr == A_CNT_HI) cnt[63:32] <= wr_data;

      if (load_ok && wr_addr == A_PRD_LO) prd[31:0]  <= wr_data;
      if (load_ok && wr_addr == A_PRD_HI) prd[63:32] <= wr_data;
    end
  end
endmodule

module wdog_keyguard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] glb_mode,
  input logic [1:0] half_run,
  input logic       wdt_rst_pulse,
  input logic       wdt_fired,
  input logic [1:0] wdt_state
);
  wire gate_on = (glb_mode == 2'b10) && (half_run == 2'b11);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_pulse |=> !wdt_rst_pulse); // R9
  AST_FIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_fired |=> wdt_fired); // R9
  AST_PULSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_pulse |-> (wdt_fired && wdt_state == 2'd0)); // R9
  AST_OFF_ONLY_BY_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_state == 2'd0 && $past(wdt_state) != 2'd0) |-> wdt_rst_pulse); // R3
  AST_PRE_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_state == 2'd1 && $past(wdt_state) != 2'd1) |-> $past(wdt_state) == 2'd0); // R2
  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |=> ($stable(wdt_state) && !wdt_rst_pulse)); // R4
endmodule

bind wdog_keyguard wdog_keyguard_chk u_chk (.*);

// File: tb/wdog_keyguard_tb.sv
module wdog_keyguard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  glb_mode = 2'b10;
  logic [1:0]  half_run = 2'b11;
  logic        wdt_rst_pulse, wdt_fired;
  logic [1:0]  wdt_state;

  int n_run = 0, n_fail = 0, cyc = 0;

  localparam logic [7:0] CLO = 8'h10, CHI = 8'h14, PLO = 8'h18, PHI = 8'h1C, CTL = 8'h28;
  localparam logic [31:0] K1 = 32'hA5C6_4000, K2 = 32'hDA7E_4000;

  always #5 clk = ~clk;

  wdog_keyguard u_dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run = n_run + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    glb_mode = 2'b10; half_run = 2'b11; wr_en = 1'b0;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic arm(input logic [31:0] plo, input logic [31:0] phi,
                     input logic [31:0] clo, input logic [31:0] chi);
    do_reset();
    wr(PLO, plo); wr(PHI, phi); wr(CLO, clo); wr(CHI, chi);
    wr(CTL, K1);
    wr(CTL, K2);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", wdt_state, 0);
    chk("R1 pulse", wdt_rst_pulse, 0);
    chk("R1 fired", wdt_fired, 0);
  endtask

  task automatic t_arm_seq();
    do_reset();
    wr(CTL, 32'hA5C6_0000);
    chk("R2 key without enable ignored", wdt_state, 0);
    wr(CTL, K2);
    chk("R2 wrong key ignored while off", wdt_state, 0);
    wr(CTL, K1);
    chk("R2 first key arms pre", wdt_state, 1);
    wr(CTL, 32'h1234_0000);
    chk("R3 wrong key ignored in pre", wdt_state, 1);
    wr(CTL, K1);
    chk("R3 repeat first key stays pre", wdt_state, 1);
    wr(CTL, K2);
    chk("R3 second key arms", wdt_state, 2);
    chk("R3 no pulse on arming", wdt_rst_pulse, 0);
  endtask

  task automatic t_gate();
    do_reset();
    glb_mode = 2'b01;
    wr(CTL, K1);
    chk("R4 wrong mode ignores key", wdt_state, 0);
    glb_mode = 2'b10; half_run = 2'b01;
    wr(CTL, K1);
    chk("R4 half in reset ignores key", wdt_state, 0);
    arm(4, 0, 0, 0);
    glb_mode = 2'b00;
    tick(20);
    chk("R4 frozen state", wdt_state, 2);
    chk("R4 frozen no pulse", wdt_rst_pulse, 0);
    wr(CTL, 32'h0000_4000);
    chk("R4 bad key ignored when gated", wdt_state, 2);
    chk("R4 bad key no pulse when gated", wdt_rst_pulse, 0);
    glb_mode = 2'b10;
    tick(4);
    chk("R4 count resumed from held value", wdt_rst_pulse, 0);
    tick(1);
    chk("R4 expiry after resume", wdt_rst_pulse, 1);
  endtask

  task automatic t_expire();
    arm(5, 0, 0, 0);
    tick(5);
    chk("R5 no pulse before period", wdt_rst_pulse, 0);
    tick(1);
    chk("R5 pulse at period", wdt_rst_pulse, 1);
    chk("R9 back to off", wdt_state, 0);
    tick(1);
    chk("R9 pulse one cycle", wdt_rst_pulse, 0);
    chk("R9 fired sticky", wdt_fired, 1);
    tick(5);
    chk("R9 fired holds", wdt_fired, 1);
    do_reset();
    chk("R9 fired cleared by reset", wdt_fired, 0);
    arm(2, 1, 32'hFFFF_FFFF, 0);
    tick(3);
    chk("R5 carry no early pulse", wdt_rst_pulse, 0);
    tick(1);
    chk("R5 carry across halves", wdt_rst_pulse, 1);
  endtask

  task automatic t_zero();
    arm(0, 0, 0, 0);
    tick(1);
    chk("R6 zero period fires at once", wdt_rst_pulse, 1);
  endtask

  task automatic t_service();
    arm(10, 0, 0, 0);
    tick(6);
    wr(CTL, K1);
    chk("R7 service half state", wdt_state, 3);
    wr(CTL, K2);
    chk("R7 service done state", wdt_state, 2);
    tick(10);
    chk("R7 counter restarted", wdt_rst_pulse, 0);
    tick(1);
    chk("R7 expiry after service", wdt_rst_pulse, 1);
  endtask

  task automatic t_badkey();
    arm(32'h1000, 0, 0, 0);
    wr(CTL, 32'h0000_4000);
    chk("R8 key zero fires", wdt_rst_pulse, 1);
    chk("R8 key zero fired flag", wdt_fired, 1);
    arm(32'h1000, 0, 0, 0);
    wr(CTL, K2);
    chk("R8 second key first fires", wdt_rst_pulse, 1);
    arm(32'h1000, 0, 0, 0);
    wr(CTL, K1);
    wr(CTL, K1);
    chk("R8 repeated first key fires", wdt_rst_pulse, 1);
  endtask

  task automatic t_lock();
    arm(8, 0, 0, 0);
    wr(PLO, 0);
    wr(CLO, 8);
    tick(6);
    chk("R10 load writes ignored when armed", wdt_rst_pulse, 0);
    tick(1);
    chk("R10 original period kept", wdt_rst_pulse, 1);
  endtask

  task automatic t_collide();
    arm(3, 0, 0, 0);
    tick(3);
    wr(CTL, 32'h0000_4000);
    chk("R11 expiry plus bad key pulse", wdt_rst_pulse, 1);
    tick(1);
    chk("R11 single pulse", wdt_rst_pulse, 0);
    arm(4, 0, 0, 0);
    wr(CTL, K1);
    tick(3);
    wr(CTL, K2);
    chk("R11 expiry beats service", wdt_rst_pulse, 1);
    chk("R11 state off", wdt_state, 0);
    tick(1);
    chk("R11 single pulse after service clash", wdt_rst_pulse, 0);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_arm_seq();
    t_gate();
    t_expire();
    t_zero();
    t_service();
    t_badkey();
    t_lock();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule